// File: doc/BRIEF.md
# Two-Wire Bus Target with 7-bit and 10-bit Addressing

This block is the target side of a two-wire serial bus (I2C). It works from a fast system clock and oversamples the clock and data lines. It drives each line only by pulling it low, and the two enables must feed open-drain pads. A static configuration picks the address the block answers to: either one 7-bit address or one 10-bit address. It finds START, repeated START and STOP conditions, decodes the address phase, and acknowledges a match by pulling the data line low during the ninth clock.

Each write byte goes out on a valid/ready byte port. Each read byte is fetched on a request/valid port. Whenever the user side is behind, the block holds the clock line low after the acknowledge: either the last received byte has not been taken, or the next byte to send is not there yet. In 10-bit mode the block follows the two-byte address write. It also follows the read form, where a repeated START carries the first address byte again with the read bit set. That read header is only taken if the full 10-bit write match is still held.

Top module: `i2c_target10`

## Requirements
- R1: After reset, scl_oe, sda_oe, rx_valid, tx_req and addressed are all 0.
- R2: ev_start pulses once when SDA falls while SCL is high, and ev_stop pulses once when SDA rises while SCL is high. addressed is 0 after either condition.
- R3: With cfg_ten_bit=0, a first byte whose bits [7:1] equal cfg_addr[6:0] is acknowledged (SDA low during the ninth clock), and addressed goes to 1. Bit 0 of that byte selects read (1) or write (0).
- R4: A 7-bit address whose upper four bits are 0000 or 1111 is never acknowledged. Addresses at the edge of these groups (0001000, 1110111) are acknowledged.
- R5: A first byte that does not match gets no acknowledge. SDA stays released and no byte reaches rx_valid until the next START.
- R6: Write bytes are taken MSB first, and every one is acknowledged. Each byte shows on rx_data with rx_valid high once its eighth bit is in. rx_valid and rx_data hold until rx_ready is seen high.
- R7: If a received byte is still not taken when the acknowledge clock ends, the target holds SCL low until rx_ready is high.
- R8: After a read address is acknowledged, tx_req is high and SCL is held low until tx_valid. The byte on tx_data is then sent MSB first, with SDA changing only while SCL is low.
- R9: If the controller acknowledges a read byte (SDA low on the ninth clock), the next byte is requested. If it does not (SDA high), the target releases SDA, asserts no tx_req, and waits for STOP or a repeated START.
- R10: With cfg_ten_bit=1, a first byte of 11110, cfg_addr[9:8], 0 is acknowledged. A following byte equal to cfg_addr[7:0] is acknowledged and sets addressed. Data bytes follow as in R6. A plain 7-bit byte is not acknowledged in this mode.
- R11: After a full 10-bit write match, a repeated START and the byte 11110, cfg_addr[9:8], 1 are acknowledged, and read bytes follow as in R8.
- R12: The 10-bit read header is refused unless a 10-bit match is held. STOP clears the match, and so does any completed first address byte other than a matching read header.
- R13: In 10-bit mode, a second address byte that differs from cfg_addr[7:0] is not acknowledged. Later data bytes are then ignored.
- R14: A repeated START in the middle of a transfer drops the partial byte, releases both lines, clears addressed and examines the next byte as a fresh address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_addr | input | 10 | Own address; only bits [6:0] are used in 7-bit mode |
| rx_valid | output | 1 | A received write byte is waiting |
| rx_data | output | 8 | Received write byte |
| rx_ready | input | 1 | User side takes the waiting byte |
| tx_req | output | 1 | Target needs the next read byte |
| tx_valid | input | 1 | tx_data holds the next read byte |
| tx_data | input | 8 | Read byte to send |
| ev_start | output | 1 | One-cycle pulse on START or repeated START |
| ev_stop | output | 1 | One-cycle pulse on STOP |
| addressed | output | 1 | Target has been selected in the current transfer |

## Verification
The bench builds the block with the default two-stage line synchronizer. A quarter bus period is six system clocks, so every bus edge reaches the target's state machine well inside the phase the bench is driving. With this setting a held-low clock line can only come from the target. The bench therefore tests stretching by holding back rx_ready or tx_valid for forty cycles and watching the wired-AND line stay low. It runs a table of address bytes against both addressing modes, then directed transfers. These cover 10-bit reads through repeated START, a stale or missing 10-bit match, a wrong low address byte, and a repeated START in the middle of a byte.

// File: rtl/i2c_t10_pkg.sv
package i2c_t10_pkg;

  localparam int BYTE_W   = 8;
  localparam int ADDR10_W = 10;
  localparam int BITC_W   = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR1,
    ST_ADR2,
    ST_ACK,
    ST_WR,
    ST_HOLD_RX,
    ST_HOLD_TX,
    ST_RD,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;

  // 7-bit addresses in the all-zero and all-one upper groups are never answered
  function automatic logic addr7_reserved(input logic [6:0] a);
    return (a[6:3] == 4'b0000) || (a[6:3] == 4'b1111);
  endfunction

  // first byte of a 10-bit address: fixed 11110 prefix then the two top address bits
  function automatic logic hdr10_hit(input logic [7:0] b, input logic [1:0] hi);
    return (b[7:3] == 5'b11110) && (b[2:1] == hi);
  endfunction

endpackage

// File: rtl/i2c_t10_sync.sv
module i2c_t10_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0]             line_in;
  logic [LINES-1:0][STAGES-1:0] sr;
  logic                         scl_d, sda_d;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr[g] <= '1;
      else        sr[g] <= {sr[g][STAGES-2:0], line_in[g]};
    end
  end

  assign scl_s = sr[0][STAGES-1];
  assign sda_s = sr[1][STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  // R2
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !stop_det);

endmodule

// File: rtl/i2c_t10_addr.sv
module i2c_t10_addr
  import i2c_t10_pkg::*;
(
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                ten_i,
  input  logic [ADDR10_W-1:0] addr_i,
  output logic                m7_o,
  output logic                hdr_w_o,
  output logic                hdr_r_o,
  output logic                low_o
);
  logic hdr;

  assign hdr     = ten_i && hdr10_hit(byte_i, addr_i[9:8]);
  assign m7_o    = !ten_i && !addr7_reserved(addr_i[6:0]) &&
                   (byte_i[BYTE_W-1:1] == addr_i[6:0]);
  assign hdr_w_o = hdr && !byte_i[0];
  assign hdr_r_o = hdr && byte_i[0];
  assign low_o   = ten_i && (byte_i == addr_i[7:0]);

endmodule

// File: rtl/i2c_target10.sv
module i2c_target10
  import i2c_t10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                scl_oe,
  output logic                sda_oe,
  input  logic                cfg_ten_bit,
  input  logic [ADDR10_W-1:0] cfg_addr,
  output logic                rx_valid,
  output logic [BYTE_W-1:0]   rx_data,
  input  logic                rx_ready,
  output logic                tx_req,
  input  logic                tx_valid,
  input  logic [BYTE_W-1:0]   tx_data,
  output logic                ev_start,
  output logic                ev_stop,
  output logic                addressed
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_t10_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_e          state, after;
  logic [BITC_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]   shreg;
  logic                sda_drv, hit10, addr_q, rxv;
  logic [BYTE_W-1:0]   rxd;

  logic m7, hdr_w, hdr_r, low_m;

  i2c_t10_addr u_addr (
    .byte_i(shreg), .ten_i(cfg_ten_bit), .addr_i(cfg_addr),
    .m7_o(m7), .hdr_w_o(hdr_w), .hdr_r_o(hdr_r), .low_o(low_m)
  );

  // named internal events
  logic       byte_done, rx_pend;
  logic       dec_ack, dec_hit10, dec_addr;
  tgt_state_e dec_next;

  assign byte_done = (bit_cnt == BITC_W'(BYTE_W));
  assign rx_pend   = rxv && !rx_ready;

  // acknowledge decision at the end of a received byte
  always_comb begin
    dec_ack   = 1'b0;
    dec_next  = ST_IDLE;
    dec_hit10 = hit10;
    dec_addr  = 1'b0;
    unique case (state)
      ST_ADR1: begin
        dec_hit10 = 1'b0;
        if (m7) begin
          dec_ack  = 1'b1;
          dec_addr = 1'b1;
          dec_next = shreg[0] ? ST_HOLD_TX : ST_WR;
        end else if (hdr_w) begin
          dec_ack  = 1'b1;
          dec_next = ST_ADR2;
        end else if (hdr_r && hit10) begin
          dec_ack   = 1'b1;
          dec_addr  = 1'b1;
          dec_hit10 = 1'b1;
          dec_next  = ST_HOLD_TX;
        end
      end
      ST_ADR2: begin
        if (low_m) begin
          dec_ack   = 1'b1;
          dec_addr  = 1'b1;
          dec_hit10 = 1'b1;
          dec_next  = ST_WR;
        end
      end
      ST_WR: begin
        dec_ack  = 1'b1;
        dec_addr = addr_q;
        dec_next = ST_WR;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      after   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      sda_drv <= 1'b0;
      hit10   <= 1'b0;
      addr_q  <= 1'b0;
      rxv     <= 1'b0;
      rxd     <= '0;
    end else begin
      if (rxv && rx_ready) rxv <= 1'b0;
      if (start_det) begin
        state   <= ST_ADR1;
        bit_cnt <= '0;
        sda_drv <= 1'b0;
        addr_q  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        sda_drv <= 1'b0;
        addr_q  <= 1'b0;
        hit10   <= 1'b0;
      end else begin
        case (state)
          ST_ADR1, ST_ADR2, ST_WR: begin
            if (scl_rise && !byte_done) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              bit_cnt <= '0;
              hit10   <= dec_hit10;
              if (dec_ack) begin
                sda_drv <= 1'b1;
                state   <= ST_ACK;
                after   <= dec_next;
                addr_q  <= dec_addr;
                if (state == ST_WR) begin
                  rxv <= 1'b1;
                  rxd <= shreg;
                end
              end else begin
                state  <= ST_IDLE;
                addr_q <= 1'b0;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_drv <= 1'b0;
              bit_cnt <= '0;
              if (after == ST_WR && rx_pend) state <= ST_HOLD_RX;
              else                           state <= after;
            end
          end
          ST_HOLD_RX: begin
            if (!rx_pend) state <= ST_WR;
          end
          ST_HOLD_TX: begin
            if (tx_valid) begin
              shreg   <= tx_data;
              sda_drv <= !tx_data[BYTE_W-1];
              bit_cnt <= '0;
              state   <= ST_RD;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_done) begin
                sda_drv <= 1'b0;
                state   <= ST_RACK;
              end else begin
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                sda_drv <= !shreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_WAIT;
            end else if (scl_fall) begin
              state <= ST_HOLD_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = sda_drv;
  assign scl_oe    = (state == ST_HOLD_TX) || (state == ST_HOLD_RX);
  assign tx_req    = (state == ST_HOLD_TX);
  assign rx_valid  = rxv;
  assign rx_data   = rxd;
  assign addressed = addr_q;
  assign ev_start  = start_det;
  assign ev_stop   = stop_det;

  // R8
  sda_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7
  stretch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !scl_s);

  // R3
  ack_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> sda_oe);

  // R14
  restart_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (!sda_oe && !scl_oe && !addressed));

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (!sda_oe && !tx_req));

endmodule

// File: tb/sim_i2c_target10.sv
module sim_i2c_target10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       scl_oe, sda_oe, rx_valid, tx_req, ev_start, ev_stop, addressed;
  logic [7:0] rx_data;
  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic       cfg_ten_bit = 1'b0;
  logic [9:0] cfg_addr = 10'h03A;
  logic       rx_ready = 1'b1;
  logic       tx_en = 1'b0;
  logic [7:0] tx_byte = 8'h96;
  logic       tx_valid;

  wire scl_line = ~(m_scl_low | scl_oe);
  wire sda_line = ~(m_sda_low | sda_oe);
  assign tx_valid = tx_en & tx_req;

  i2c_target10 u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_ten_bit(cfg_ten_bit), .cfg_addr(cfg_addr),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_byte),
    .ev_start(ev_start), .ev_stop(ev_stop), .addressed(addressed)
  );

  logic [7:0] rx_log [0:15];
  int rx_n = 0, n_start = 0, n_stop = 0;
  int checks = 0, errors = 0;

  always @(posedge clk) begin
    if (tx_req && tx_valid) tx_byte <= tx_byte + 8'h35;
    if (rx_valid && rx_ready) begin
      rx_log[rx_n[3:0]] <= rx_data;
      rx_n <= rx_n + 1;
    end
    if (ev_start) n_start <= n_start + 1;
    if (ev_stop)  n_stop  <= n_stop + 1;
  end

  typedef struct packed {
    logic       ten;
    logic [9:0] addr;
    logic [7:0] byte0;
    logic       ack;
    logic       adr;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{1'b0, 10'h03A, 8'h74, 1'b1, 1'b1},  // R3 match, write
    '{1'b0, 10'h03A, 8'h76, 1'b0, 1'b0},  // R5 other address
    '{1'b0, 10'h005, 8'h0A, 1'b0, 1'b0},  // R4 low reserved group
    '{1'b0, 10'h07C, 8'hF8, 1'b0, 1'b0},  // R4 high reserved group
    '{1'b0, 10'h008, 8'h10, 1'b1, 1'b1},  // R4 just above low group
    '{1'b0, 10'h077, 8'hEE, 1'b1, 1'b1},  // R4 just below high group
    '{1'b1, 10'h2C5, 8'hF4, 1'b1, 1'b0},  // R10 header write
    '{1'b1, 10'h2C5, 8'hF2, 1'b0, 1'b0},  // R10 wrong top bits
    '{1'b1, 10'h2C5, 8'h8A, 1'b0, 1'b0},  // R10 7-bit form refused in 10-bit mode
    '{1'b1, 10'h2C5, 8'hF5, 1'b0, 1'b0}   // R12 read header with no match held
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    do @(negedge clk); while (!scl_line);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda_low = !b;
    wq();
    m_scl_low = 1'b0;
    wait_scl_high();
    wq();
    r = sda_line;
    wq();
    m_scl_low = 1'b1;
    wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(!give_ack, r);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b1; wq();
    m_scl_low = 1'b1; wq();
  endtask

  task automatic bus_rstart();
    m_sda_low = 1'b0; wq();
    m_scl_low = 1'b0; wait_scl_high(); wq();
    m_sda_low = 1'b1; wq();
    m_scl_low = 1'b1; wq();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wq();
    m_scl_low = 1'b0; wait_scl_high(); wq();
    m_sda_low = 1'b0; wq(); wq();
  endtask

  // first 10-bit address byte built from the address and direction
  function automatic logic [7:0] hdr_of(input logic [9:0] a, input logic rd);
    return 8'hF0 | {5'b0, a[9], a[8], rd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic       ack, r;
    logic [7:0] b;
    logic [7:0] exp_tx;
    int         base, s0, p0;
    vec_t       v;
    exp_tx = 8'h96;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_req", tx_req, 0);
    chk("R1 addressed", addressed, 0);
    rst_n = 1'b1;
    wq();

    s0 = n_start; p0 = n_stop;
    for (int i = 0; i < 10; i++) begin
      v = VECS[i];
      cfg_ten_bit = v.ten;
      cfg_addr    = v.addr;
      wq();
      bus_start();
      send_byte(v.byte0, ack);
      chk($sformatf("R3/R4/R5/R10/R12 vec %0d ack", i), ack, v.ack);
      chk($sformatf("R3/R10 vec %0d addressed", i), addressed, v.adr);
      bus_stop();
      chk($sformatf("R2 vec %0d addressed after stop", i), addressed, 0);
    end
    chk("R2 start count", n_start - s0, 10);
    chk("R2 stop count", n_stop - p0, 10);

    // R6 7-bit write, two bytes
    cfg_ten_bit = 1'b0; cfg_addr = 10'h03A; rx_ready = 1'b1;
    base = rx_n;
    bus_start();
    send_byte(8'h74, ack); chk("R6 addr ack", ack, 1);
    send_byte(8'hA5, ack); chk("R6 data0 ack", ack, 1);
    send_byte(8'h3C, ack); chk("R6 data1 ack", ack, 1);
    bus_stop();
    chk("R6 rx count", rx_n - base, 2);
    chk("R6 rx byte0", rx_log[base[3:0]], 8'hA5);
    chk("R6 rx byte1", rx_log[4'(base + 1)], 8'h3C);

    // R7 stretch while the received byte is not taken
    rx_ready = 1'b0;
    base = rx_n;
    bus_start();
    send_byte(8'h74, ack); chk("R7 addr ack", ack, 1);
    send_byte(8'h5A, ack); chk("R7 data ack", ack, 1);
    fork
      send_byte(8'hC3, ack);
      begin
        repeat (40) @(negedge clk);
        chk("R7 scl held low", scl_line, 0);
        chk("R7 rx_valid pending", rx_valid, 1);
        chk("R7 rx_data pending", rx_data, 8'h5A);
        rx_ready = 1'b1;
      end
    join
    chk("R7 second byte ack", ack, 1);
    bus_stop();
    chk("R7 rx byte0", rx_log[base[3:0]], 8'h5A);
    chk("R7 rx byte1", rx_log[4'(base + 1)], 8'hC3);

    // R8 read with late data, R9 ack then nack
    tx_en = 1'b0;
    bus_start();
    send_byte(8'h75, ack); chk("R8 read addr ack", ack, 1);
    fork
      recv_byte(1'b1, b);
      begin
        repeat (40) @(negedge clk);
        chk("R8 tx_req", tx_req, 1);
        chk("R8 scl held low", scl_line, 0);
        tx_en = 1'b1;
      end
    join
    chk("R8 read byte0", b, exp_tx); exp_tx = exp_tx + 8'h35;
    recv_byte(1'b0, b);
    chk("R9 read byte1 after ack", b, exp_tx); exp_tx = exp_tx + 8'h35;
    repeat (30) @(negedge clk);
    chk("R9 no tx_req after nack", tx_req, 0);
    chk("R9 sda released after nack", sda_oe, 0);
    bus_stop();

    // R10 10-bit write
    cfg_ten_bit = 1'b1; cfg_addr = 10'h2C5;
    base = rx_n;
    bus_start();
    send_byte(hdr_of(cfg_addr, 1'b0), ack); chk("R10 header ack", ack, 1);
    chk("R10 not yet addressed", addressed, 0);
    send_byte(cfg_addr[7:0], ack); chk("R10 low byte ack", ack, 1);
    chk("R10 addressed", addressed, 1);
    send_byte(8'h69, ack); chk("R10 data ack", ack, 1);
    bus_stop();
    chk("R10 rx byte", rx_log[base[3:0]], 8'h69);

    // R11 10-bit read through repeated start
    bus_start();
    send_byte(hdr_of(cfg_addr, 1'b0), ack);
    send_byte(cfg_addr[7:0], ack);
    bus_rstart();
    send_byte(hdr_of(cfg_addr, 1'b1), ack); chk("R11 read header ack", ack, 1);
    chk("R11 addressed", addressed, 1);
    recv_byte(1'b0, b);
    chk("R11 read byte", b, exp_tx); exp_tx = exp_tx + 8'h35;
    bus_stop();

    // R12 match cleared by stop
    bus_start();
    send_byte(hdr_of(cfg_addr, 1'b1), ack); chk("R12 read header after stop", ack, 0);
    bus_stop();
    // R12 match cleared by another address byte
    bus_start();
    send_byte(hdr_of(cfg_addr, 1'b0), ack);
    send_byte(cfg_addr[7:0], ack);
    bus_rstart();
    send_byte(8'h8A, ack); chk("R12 foreign byte nack", ack, 0);
    bus_rstart();
    send_byte(hdr_of(cfg_addr, 1'b1), ack); chk("R12 read header after foreign byte", ack, 0);
    bus_stop();

    // R13 wrong low address byte
    base = rx_n;
    bus_start();
    send_byte(hdr_of(cfg_addr, 1'b0), ack); chk("R13 header ack", ack, 1);
    send_byte(8'hC4, ack); chk("R13 low byte nack", ack, 0);
    send_byte(8'h11, ack); chk("R13 data ignored", ack, 0);
    chk("R13 addressed", addressed, 0);
    bus_stop();
    chk("R13 no rx", rx_n - base, 0);

    // R14 repeated start inside a data byte
    cfg_ten_bit = 1'b0; cfg_addr = 10'h03A;
    base = rx_n;
    bus_start();
    send_byte(8'h74, ack); chk("R14 addr ack", ack, 1);
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b1, r);
    bus_rstart();
    chk("R14 addressed cleared", addressed, 0);
    send_byte(8'h76, ack); chk("R14 other address nack", ack, 0);
    bus_stop();
    chk("R14 partial byte dropped", rx_n - base, 0);
    bus_start();
    send_byte(8'h74, ack);
    clk_bit(1'b0, r); clk_bit(1'b1, r);
    bus_rstart();
    send_byte(8'h74, ack); chk("R14 re-examined addr ack", ack, 1);
    send_byte(8'h5E, ack); chk("R14 data ack", ack, 1);
    bus_stop();
    chk("R14 rx count", rx_n - base, 1);
    chk("R14 rx byte", rx_log[base[3:0]], 8'h5E);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule